// File: doc/BRIEF.md
# Exception Entry Vector Sequencer

This block sits beside a processor's control-register file and performs the register side of taking an exception. When the pipeline raises a request, it chooses the handler address and writes the saved return address and the cause and status fields. The handler address depends on the boot-vector select, the exception base, the kind of exception, whether a TLB refill can use its dedicated entry point, and, for interrupts, the vectoring scheme and the spacing between vectors. The return address backs up over a branch when the faulting instruction sat in its delay slot.

The request is a one-cycle `exc_valid` strobe with a 6-bit kind. When `exc_kind[5]` is 0, `exc_kind[4:0]` is the architectural exception code. The codes are: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4/5 address error load/store, 6/7 instruction/data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 18 coprocessor-2, 19 read-inhibit, 20 execute-inhibit, 24 machine check and 30 cache error. When `exc_kind[5]` is 1, the kind is special. 0x20 is non-maskable interrupt and 0x21 is soft reset, and both take the error path. 0x22 (any special kind with bit 1 set) is a debug exception. All outputs are registered and are updated at the clock edge that samples the strobe.

A two-state machine controls the sequence. `ST_IDLE` moves to `ST_ENTER` when a request arrives. `ST_ENTER` stays in `ST_ENTER` if another request arrives on the next cycle, and returns to `ST_IDLE` otherwise. The `redirect` output is high exactly while the machine is in `ST_ENTER`, and `target_pc` holds the handler address at that time.

Top module: `exc_entry_seq`

## Requirements
- R1: For a general kind, the handler address is base + offset. The base is 0xBFC00200 when `st_bev`=1 and `ebase` with bits [9:0] cleared when `st_bev`=0. The offset is 0x180 unless R2 to R4 select another.
- R2: Codes 2 and 3 with `tlb_refill`=1 and `st_exl`=0 use offset 0x000. With `st_exl`=1 they use 0x180.
- R3: Code 30 uses offset 0x100 when `st_bev`=1 and 0x20000100 when `st_bev`=0.
- R4: Code 0 uses offset 0x200 when `iv_sel`=1 and 0x180 when `iv_sel`=0, provided `vec_mode`=0. When `vec_mode` is not 0, the offset is 0x200 + vector × (`vs_field` × 32), whatever `iv_sel` is.
- R5: The vector is formed from `irq_pend & irq_mask`. When `vec_mode[1]`=0 it is the highest set line among 7 down to 1, or 0 if none of those lines is set. When `vec_mode[1]`=1 it is the masked value itself.
- R6: A general kind with `st_exl`=0 loads `epc` with the resume PC. The resume PC is `exc_pc`, minus 4 when `in_delay`=1, or minus 2 when `in_delay`=1 and `br16`=1. `cause[31]` takes `in_delay` and `new_exl` becomes 1. In every case `cause[6:2]` takes the code, and all other cause bits read 0.
- R7: A general kind with `st_exl`=1 leaves `epc` and `cause[31]` unchanged and still writes `cause[6:2]`. The status outputs take `new_exl`=1 and copy `st_erl` and `st_bev`.
- R8: Kinds 0x20 and 0x21 load `error_epc` with the resume PC, set `new_erl` and `new_bev`, copy `st_exl` to `new_exl` and send the handler to 0xBFC00000. They clear `cause[31]` only if `st_exl`=0 and leave `cause[6:2]` unchanged.
- R9: Kind 0x22 loads `depc` with the resume PC and sends the handler to 0xBFC00480. It copies the status inputs to the status outputs, clears `cause[31]` only if `st_exl`=0 and leaves `cause[6:2]` unchanged.
- R10: The outputs change at the edge that samples `exc_valid`=1. `redirect` is 1 in the following cycle only, and stays 1 over back-to-back requests.
- R11: After reset, `redirect`, `target_pc`, `epc`, `error_epc`, `depc`, `cause` and the three status outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_kind | input | 6 | Exception kind (code or special kind) |
| exc_pc | input | XLEN | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction is in a delay slot |
| br16 | input | 1 | The branch before the slot is 16 bits long |
| tlb_refill | input | 1 | TLB fault is a refill (no matching entry) |
| st_exl | input | 1 | Current exception-level bit |
| st_erl | input | 1 | Current error-level bit |
| st_bev | input | 1 | Current boot-vector select |
| iv_sel | input | 1 | Interrupts use the dedicated offset |
| ebase | input | XLEN | Exception base register |
| vs_field | input | VS_W | Vector spacing field |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_mask | input | NUM_IRQ | Interrupt enable mask |
| vec_mode | input | 2 | 0 unvectored, bit1=0 internal priority, bit1=1 external vector |
| redirect | output | 1 | Fetch redirect pulse |
| target_pc | output | XLEN | Handler address |
| epc | output | XLEN | Exception return address |
| error_epc | output | XLEN | Error return address |
| depc | output | XLEN | Debug return address |
| cause | output | 32 | Cause: code in [6:2], delay-slot bit at 31 |
| new_exl | output | 1 | Updated exception-level bit |
| new_erl | output | 1 | Updated error-level bit |
| new_bev | output | 1 | Updated boot-vector select |

## Verification
The two functions that share a cycle are the refill entry-point choice and the exception-level guard on `epc`. A TLB refill that arrives while `st_exl` is already 1 must move the handler offset from 0x000 to 0x180 and must also hold `epc` and the delay-slot bit, both from the same sampled `st_exl`. The sweep drives every code with every combination of `st_exl`, `tlb_refill`, `st_bev` and the three delay-slot forms as back-to-back requests. After each edge it compares the handler address and every saved register with values that the bench computes arithmetically. In a second sweep, all 256 pending patterns, under two masks and all vectoring modes, check the vector priority and the spacing product in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ENTER = 1'b1
    } seq_state_t;

    localparam logic [4:0] CODE_INT   = 5'd0;
    localparam logic [4:0] CODE_TLBL  = 5'd2;
    localparam logic [4:0] CODE_TLBS  = 5'd3;
    localparam logic [4:0] CODE_CACHE = 5'd30;

    localparam logic [31:0] BEV_BASE    = 32'hBFC0_0200;
    localparam logic [31:0] RESET_VEC   = 32'hBFC0_0000;
    localparam logic [31:0] DEBUG_VEC   = 32'hBFC0_0480;
    localparam logic [31:0] OFF_GENERAL = 32'h0000_0180;
    localparam logic [31:0] OFF_IRQ     = 32'h0000_0200;
    localparam logic [31:0] OFF_CACHE_B = 32'h0000_0100;
    localparam logic [31:0] OFF_CACHE_N = 32'h2000_0100;
    localparam int          BASE_LSBS   = 10;
    localparam int          SPACE_SHIFT = 5;
endpackage

// File: rtl/exc_irq_prio.sv
module exc_irq_prio #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               ext_mode,
    output logic [NUM_IRQ-1:0] vec
);
    logic [NUM_IRQ-1:0] active;
    logic [NUM_IRQ-1:0] prio;

    assign active = irq_pend & irq_mask;

    // Ascending scan: the last (highest) active line above 0 wins.
    always_comb begin
        prio = '0;
        for (int i = 1; i < NUM_IRQ; i++) begin
            if (active[i]) prio = NUM_IRQ'(i);
        end
    end

    assign vec = ext_mode ? active : prio;
endmodule

// File: rtl/exc_resume.sv
module exc_resume #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_in,
    input  logic            in_delay,
    input  logic            br16,
    output logic [XLEN-1:0] resume_pc
);
    logic [XLEN-1:0] back;

    assign back      = br16 ? XLEN'(2) : XLEN'(4);
    assign resume_pc = in_delay ? (pc_in - back) : pc_in;
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 8,
    parameter int VS_W    = 5
) (
    input  logic [4:0]         code,
    input  logic               is_err,
    input  logic               is_dbg,
    input  logic               bev,
    input  logic               exl,
    input  logic               refill,
    input  logic               iv_sel,
    input  logic [1:0]         vec_mode,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic [VS_W-1:0]    vs_field,
    input  logic [XLEN-1:0]    ebase,
    output logic [XLEN-1:0]    handler_pc
);
    localparam logic [XLEN-1:0] LOW_MASK = XLEN'((1 << BASE_LSBS) - 1);

    logic [NUM_IRQ-1:0] vec;
    logic [XLEN-1:0]    base;
    logic [XLEN-1:0]    offset;
    logic [XLEN-1:0]    spacing;

    exc_irq_prio #(.NUM_IRQ(NUM_IRQ)) i_prio (
        .irq_pend (irq_pend),
        .irq_mask (irq_mask),
        .ext_mode (vec_mode[1]),
        .vec      (vec)
    );

    assign spacing = XLEN'(vs_field) << SPACE_SHIFT;

    always_comb begin
        base   = bev ? XLEN'(BEV_BASE) : (ebase & ~LOW_MASK);
        offset = XLEN'(OFF_GENERAL);
        if (code == CODE_INT) begin
            if (iv_sel) offset = XLEN'(OFF_IRQ);
            if (vec_mode != 2'b00) offset = XLEN'(OFF_IRQ) + XLEN'(vec) * spacing;
        end else if ((code == CODE_TLBL || code == CODE_TLBS) && refill && !exl) begin
            offset = '0;
        end else if (code == CODE_CACHE) begin
            offset = bev ? XLEN'(OFF_CACHE_B) : XLEN'(OFF_CACHE_N);
        end

        if (is_err)      handler_pc = XLEN'(RESET_VEC);
        else if (is_dbg) handler_pc = XLEN'(DEBUG_VEC);
        else             handler_pc = base + offset;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 8,
    parameter int VS_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [5:0]         exc_kind,
    input  logic [XLEN-1:0]    exc_pc,
    input  logic               in_delay,
    input  logic               br16,
    input  logic               tlb_refill,
    input  logic               st_exl,
    input  logic               st_erl,
    input  logic               st_bev,
    input  logic               iv_sel,
    input  logic [XLEN-1:0]    ebase,
    input  logic [VS_W-1:0]    vs_field,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic [1:0]         vec_mode,
    output logic               redirect,
    output logic [XLEN-1:0]    target_pc,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    error_epc,
    output logic [XLEN-1:0]    depc,
    output logic [31:0]        cause,
    output logic               new_exl,
    output logic               new_erl,
    output logic               new_bev
);
    localparam int CAUSE_PAD = 32 - 1 - 5 - 2;

    seq_state_t      state_q, state_d;
    logic            is_special, is_err, is_dbg;
    logic [XLEN-1:0] resume_pc, handler_pc;
    logic [4:0]      code_q;
    logic            bd_q;

    assign is_special = exc_kind[5];
    assign is_err     = is_special && !exc_kind[1];
    assign is_dbg     = is_special && exc_kind[1];

    exc_resume #(.XLEN(XLEN)) i_resume (
        .pc_in     (exc_pc),
        .in_delay  (in_delay),
        .br16      (br16),
        .resume_pc (resume_pc)
    );

    exc_vector_sel #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .VS_W(VS_W)) i_vsel (
        .code       (exc_kind[4:0]),
        .is_err     (is_err),
        .is_dbg     (is_dbg),
        .bev        (st_bev),
        .exl        (st_exl),
        .refill     (tlb_refill),
        .iv_sel     (iv_sel),
        .vec_mode   (vec_mode),
        .irq_pend   (irq_pend),
        .irq_mask   (irq_mask),
        .vs_field   (vs_field),
        .ebase      (ebase),
        .handler_pc (handler_pc)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = exc_valid ? ST_ENTER : ST_IDLE;
            ST_ENTER: state_d = exc_valid ? ST_ENTER : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_pc <= '0;
            epc       <= '0;
            error_epc <= '0;
            depc      <= '0;
            code_q    <= '0;
            bd_q      <= 1'b0;
            new_exl   <= 1'b0;
            new_erl   <= 1'b0;
            new_bev   <= 1'b0;
        end else if (exc_valid) begin
            target_pc <= handler_pc;
            if (is_err) begin
                error_epc <= resume_pc;
                if (!st_exl) bd_q <= 1'b0;
                new_exl <= st_exl;
                new_erl <= 1'b1;
                new_bev <= 1'b1;
            end else if (is_dbg) begin
                depc <= resume_pc;
                if (!st_exl) bd_q <= 1'b0;
                new_exl <= st_exl;
                new_erl <= st_erl;
                new_bev <= st_bev;
            end else begin
                code_q <= exc_kind[4:0];
                if (!st_exl) begin
                    epc  <= resume_pc;
                    bd_q <= in_delay;
                end
                new_exl <= 1'b1;
                new_erl <= st_erl;
                new_bev <= st_bev;
            end
        end
    end

    assign redirect = (state_q == ST_ENTER);
    assign cause    = {bd_q, {CAUSE_PAD{1'b0}}, code_q, 2'b00};
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_valid,
    input logic [5:0]      exc_kind,
    input logic            in_delay,
    input logic            st_exl,
    input logic            st_bev,
    input logic            redirect,
    input logic [XLEN-1:0] target_pc,
    input logic [XLEN-1:0] epc,
    input logic [31:0]     cause,
    input logic            new_exl,
    input logic            new_erl,
    input logic            new_bev
);
    assert_redirect_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> redirect);

    assert_redirect_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> !redirect);

    assert_first_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_kind[5] && !st_exl) |=> (new_exl && (cause[31] == $past(in_delay))));

    assert_nested_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_kind[5] && st_exl) |=> ($stable(epc) && $stable(cause[31]) && new_exl));

    assert_error_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind[5] && !exc_kind[1]) |=>
        (target_pc == XLEN'(32'hBFC0_0000) && new_erl && new_bev));

    assert_debug_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind[5] && exc_kind[1]) |=> (target_pc == XLEN'(32'hBFC0_0480)));

    assert_boot_general_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_kind[5] && st_bev && exc_kind[4:0] != 5'd0 &&
         exc_kind[4:0] != 5'd2 && exc_kind[4:0] != 5'd3 && exc_kind[4:0] != 5'd30)
        |=> (target_pc == XLEN'(32'hBFC0_0380)));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [5:0]  exc_kind = '0;
    logic [31:0] exc_pc = '0;
    logic        in_delay = 1'b0, br16 = 1'b0, tlb_refill = 1'b0;
    logic        st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0, iv_sel = 1'b0;
    logic [31:0] ebase = '0;
    logic [4:0]  vs_field = '0;
    logic [7:0]  irq_pend = '0, irq_mask = '0;
    logic [1:0]  vec_mode = '0;
    logic        redirect;
    logic [31:0] target_pc, epc, error_epc, depc, cause;
    logic        new_exl, new_erl, new_bev;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] e_pc = 0, e_epc = 0, e_eepc = 0, e_depc = 0;
    logic [4:0]  e_code = 0;
    logic        e_bd = 0, e_exl = 0, e_erl = 0, e_bev = 0;
    string       pc_tag;

    always #5 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_pc(input logic [5:0] k);
        logic [31:0] base, off;
        logic [7:0]  act, v;
        if (k[5]) return k[1] ? 32'hBFC0_0480 : 32'hBFC0_0000;
        base = st_bev ? 32'hBFC0_0200 : {ebase[31:10], 10'd0};
        off  = 32'h180;
        if (k[4:0] == 0) begin
            if (iv_sel) off = 32'h200;
            if (vec_mode != 0) begin
                act = irq_pend & irq_mask;
                v = 0;
                if (vec_mode[1]) v = act;
                else
                    for (int i = 7; i >= 1; i--) if (act[i]) begin v = 8'(i); break; end
                off = 32'h200 + 32'(v) * (32'(vs_field) * 32);
            end
        end else if ((k[4:0] == 2 || k[4:0] == 3) && tlb_refill && !st_exl) off = 0;
        else if (k[4:0] == 30) off = st_bev ? 32'h100 : 32'h2000_0100;
        return base + off;
    endfunction

    // Drive one request (exc_valid stays 1), then check at the next falling edge.
    task automatic apply(input logic [5:0] k);
        logic [31:0] res;
        exc_kind  = k;
        exc_valid = 1'b1;
        res  = in_delay ? exc_pc - (br16 ? 32'd2 : 32'd4) : exc_pc;
        e_pc = model_pc(k);
        if (k[5] && !k[1]) begin
            e_eepc = res; e_erl = 1; e_bev = 1; e_exl = st_exl;
            if (!st_exl) e_bd = 0;
            pc_tag = "R8 pc";
        end else if (k[5]) begin
            e_depc = res; e_exl = st_exl; e_erl = st_erl; e_bev = st_bev;
            if (!st_exl) e_bd = 0;
            pc_tag = "R9 pc";
        end else begin
            e_code = k[4:0];
            if (!st_exl) begin e_epc = res; e_bd = in_delay; end
            e_exl = 1; e_erl = st_erl; e_bev = st_bev;
            pc_tag = (k[4:0] == 0) ? "R4/R5 pc" : (k[4:0] == 30) ? "R3 pc" :
                     (k[4:0] == 2 || k[4:0] == 3) ? "R2 pc" : "R1 pc";
        end
        @(negedge clk);
        chk("R10 redirect", {31'd0, redirect}, 32'd1);
        chk(pc_tag, target_pc, e_pc);
        chk(st_exl ? "R7 epc" : "R6 epc", epc, e_epc);
        chk("R8 error_epc", error_epc, e_eepc);
        chk("R9 depc", depc, e_depc);
        chk(st_exl ? "R7 cause" : "R6 cause", cause, {e_bd, 24'd0, e_code, 2'b00});
        chk("R6 status", {29'd0, new_exl, new_erl, new_bev}, {29'd0, e_exl, e_erl, e_bev});
    endtask

    task automatic go_idle();
        exc_valid = 1'b0;
        @(negedge clk);
        chk("R10 redirect low", {31'd0, redirect}, 32'd0);
        chk("R10 hold pc", target_pc, e_pc);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 redirect", {31'd0, redirect}, 32'd0);
        chk("R11 pc", target_pc, 0);
        chk("R11 epc", epc, 0);
        chk("R11 error_epc", error_epc, 0);
        chk("R11 depc", depc, 0);
        chk("R11 cause", cause, 0);
        chk("R11 status", {29'd0, new_exl, new_erl, new_bev}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle", {31'd0, redirect}, 32'd0);

        ebase = 32'h8001_2345;
        // Sweep every code and special kind over status, refill and delay forms.
        for (int k = 0; k < 35; k++) begin
            for (int m = 0; m < 24; m++) begin
                st_bev     = m[0];
                st_exl     = m[1];
                tlb_refill = m[2];
                st_erl     = m[4];
                in_delay   = (m[4:3] != 0);
                br16       = (m[4:3] == 2);
                exc_pc     = 32'h0040_1000 + 32'(k * 64 + m * 4);
                iv_sel     = m[3];
                vec_mode   = 0;
                apply((k < 32) ? 6'(k) : 6'(32 + k - 32));
            end
            if (k % 8 == 0) go_idle();
        end
        go_idle();

        // Interrupt vectoring sweep (R4, R5).
        st_exl = 0; tlb_refill = 0; in_delay = 0; br16 = 0;
        for (int p = 0; p < 256; p++) begin
            for (int vm = 0; vm < 4; vm++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    irq_pend = 8'(p);
                    irq_mask = p[0] ? 8'hFF : 8'h5A;
                    vec_mode = 2'(vm);
                    iv_sel   = iv[0];
                    vs_field = 5'((p + vm) % 32);
                    st_bev   = p[1];
                    exc_pc   = 32'h0080_0000 + 32'(p * 8);
                    apply(6'h00);
                end
            end
        end
        go_idle();

        // Refill arriving under EXL, then a nested debug request (R2, R7, R9).
        st_exl = 1; tlb_refill = 1; st_bev = 0; exc_pc = 32'h0000_7000; in_delay = 1;
        apply(6'h02);
        apply(6'h22);
        go_idle();

        done = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule